// File: doc/BRIEF.md
# Branch History Table Predictor

The block predicts the next fetch address for an instruction fetch unit. It is a direct-mapped table of sixteen entries. Each entry holds a valid flag, the upper bits of a branch's address as a tag, the branch's last taken target, and a two-bit saturating direction counter. Every cycle the lookup side receives the fetch PC. On a hit, the block returns the stored target when the counter leans taken. Otherwise it returns PC + 4. It also reports whether the lookup hit and whether it predicted taken.

Branch resolution arrives on the update side with the branch PC, the actual outcome and the actual target. The block performs a second table read for that PC. It then reports whether the prediction for that branch would have sent fetch to the wrong place, and if so it gives the corrected address. On a hit the entry's counter moves one step toward the outcome. On a miss the entry at that index is overwritten with the resolved branch.

Top module: `bht_predictor`

## Requirements
- R1: While reset is applied and after its release, before any update, no lookup hits. The predicted next address is the lookup PC + 4 and the taken flag is low.
- R2: The entry index is PC bits [5:2]. The tag is PC bits [31:6]. A lookup hits only when the indexed entry is valid and its tag equals the PC's upper bits.
- R3: A lookup that misses predicts not taken, with next address PC + 4.
- R4: Counter values are 0 and 1 for not taken and 2 and 3 for taken. On a hit, a value of 2 or 3 gives the stored target with the taken flag high. A value of 0 or 1 gives PC + 4 with the taken flag low.
- R5: An update that misses writes the indexed entry as valid with the update PC's tag and the update target. Its counter is set to 2 for a taken outcome or to 1 for a not-taken outcome.
- R6: An update that hits raises the counter by one on taken, saturating at 3, and lowers it by one on not taken, saturating at 0. A taken outcome also replaces the stored target with the update target.
- R7: From counter value 3, one not-taken outcome leaves the prediction taken and a second one makes it not taken. The same holds in the opposite direction from counter value 0.
- R8: When update enable is high, the redirect flag is high exactly when the table's prediction for the update PC differs from the resolved address. The resolved address, which the correct-address output always shows, is the update target if taken and the update PC + 4 otherwise. With update enable low, the redirect flag is low.
- R9: When a lookup and an update address the same entry in one cycle, the lookup sees the entry's contents as they were before that update.
- R10: With update enable low, the table does not change, whatever the other update inputs carry.
- R11: An update to a PC whose index matches a valid entry with a different tag replaces that entry. A later lookup of the old PC then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | 32 | Fetch PC to predict for |
| pred_next | output | 32 | Predicted next fetch address |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Lookup predicted taken |
| upd_en | input | 1 | Resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | 32 | Resolved target address |
| upd_redirect | output | 1 | The prediction for the resolved branch was wrong |
| upd_fix_addr | output | 32 | Correct next address for the resolved branch |

## Verification
Lookup and update can act on the same entry in one cycle. In that case the lookup must reflect the contents before the write, and the write must land for the following cycle. The bench forces this case directly by putting the same PC on both sides, including a PC that has not been allocated yet and one whose counter is about to flip. It also reaches the case often through random traffic drawn from a small pool of PCs that alias on the index. A behavioural model, updated only after the clock edge, supplies the expected lookup result and redirect for every cycle.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  // Direction counter: values 0..1 lean not taken, 2..3 lean taken.
  typedef enum logic [1:0] {
    CNT_STRONG_NT = 2'b00,
    CNT_WEAK_NT   = 2'b01,
    CNT_WEAK_T    = 2'b10,
    CNT_STRONG_T  = 2'b11
  } cnt_e;

  function automatic logic cnt_leans_taken(input cnt_e c);
    return c[1];
  endfunction

  // Saturating step toward the resolved outcome.
  function automatic cnt_e cnt_step(input cnt_e c, input logic taken);
    cnt_e r;
    r = c;
    if (taken) begin
      if (c != CNT_STRONG_T) r = cnt_e'(c + 2'd1);
    end else begin
      if (c != CNT_STRONG_NT) r = cnt_e'(c - 2'd1);
    end
    return r;
  endfunction

  // State given to a freshly written entry.
  function automatic cnt_e cnt_alloc(input logic taken);
    return taken ? CNT_WEAK_T : CNT_WEAK_NT;
  endfunction

endpackage

// File: rtl/bhp_rst_sync.sv
module bhp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/bhp_entry.sv
module bhp_entry
  import bhp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 26
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  cnt_e              wr_cnt,
  output logic              ent_vld,
  output logic [TAG_W-1:0]  ent_tag,
  output logic [ADDR_W-1:0] ent_target,
  output cnt_e              ent_cnt
);

  logic              vld_d;
  logic [TAG_W-1:0]  tag_d;
  logic [ADDR_W-1:0] tgt_d;
  cnt_e              cnt_d;

  // Next-state: hold unless written.
  always_comb begin
    vld_d = ent_vld;
    tag_d = ent_tag;
    tgt_d = ent_target;
    cnt_d = ent_cnt;
    if (wr_en) begin
      vld_d = 1'b1;
      tag_d = wr_tag;
      tgt_d = wr_target;
      cnt_d = wr_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ent_vld    <= 1'b0;
      ent_tag    <= '0;
      ent_target <= '0;
      ent_cnt    <= CNT_STRONG_NT;
    end else begin
      ent_vld    <= vld_d;
      ent_tag    <= tag_d;
      ent_target <= tgt_d;
      ent_cnt    <= cnt_d;
    end
  end

endmodule

// File: rtl/bhp_read.sv
module bhp_read
  import bhp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26,
  parameter int ENTRIES = 16
) (
  input  logic                             [ADDR_W-1:0] pc,
  input  logic [ENTRIES-1:0]                            tbl_vld,
  input  logic [ENTRIES-1:0]               [TAG_W-1:0]  tbl_tag,
  input  logic [ENTRIES-1:0]               [ADDR_W-1:0] tbl_tgt,
  input  logic [ENTRIES-1:0]               [1:0]        tbl_cnt,
  output logic                                          rd_hit,
  output logic                                          rd_taken,
  output logic                             [ADDR_W-1:0] rd_next,
  output logic                             [ADDR_W-1:0] rd_target,
  output cnt_e                                          rd_cnt
);

  localparam int OFF_W = 2;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [ADDR_W-1:0] seq_addr;

  always_comb begin
    idx       = pc[OFF_W +: IDX_W];
    tag       = pc[ADDR_W-1 -: TAG_W];
    seq_addr  = pc + ADDR_W'(4);
    rd_target = tbl_tgt[idx];
    rd_cnt    = cnt_e'(tbl_cnt[idx]);
    rd_hit    = tbl_vld[idx] && (tbl_tag[idx] == tag);
    rd_taken  = rd_hit && cnt_leans_taken(rd_cnt);
    rd_next   = rd_taken ? rd_target : seq_addr;
  end

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bhp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic [ADDR_W-1:0] pred_next,
  output logic              pred_hit,
  output logic              pred_taken,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              upd_redirect,
  output logic [ADDR_W-1:0] upd_fix_addr
);

  localparam int OFF_W   = 2;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;

  logic rst_ok;

  logic [ENTRIES-1:0]              tbl_vld;
  logic [ENTRIES-1:0][TAG_W-1:0]   tbl_tag;
  logic [ENTRIES-1:0][ADDR_W-1:0]  tbl_tgt;
  logic [ENTRIES-1:0][1:0]         tbl_cnt;

  logic              up_hit;
  logic              up_taken_pred;
  logic [ADDR_W-1:0] up_next;
  logic [ADDR_W-1:0] up_old_tgt;
  cnt_e              up_cnt;

  logic [ADDR_W-1:0] lk_tgt_unused;
  cnt_e              lk_cnt_unused;

  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [ADDR_W-1:0] wr_target;
  cnt_e              wr_cnt;

  bhp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  // Lookup port: fetch-side read of the registered table.
  bhp_read #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)
  ) u_lk (
    .pc        (lk_pc),
    .tbl_vld   (tbl_vld),
    .tbl_tag   (tbl_tag),
    .tbl_tgt   (tbl_tgt),
    .tbl_cnt   (tbl_cnt),
    .rd_hit    (pred_hit),
    .rd_taken  (pred_taken),
    .rd_next   (pred_next),
    .rd_target (lk_tgt_unused),
    .rd_cnt    (lk_cnt_unused)
  );

  // Update port: read for the resolved branch.
  bhp_read #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)
  ) u_up (
    .pc        (upd_pc),
    .tbl_vld   (tbl_vld),
    .tbl_tag   (tbl_tag),
    .tbl_tgt   (tbl_tgt),
    .tbl_cnt   (tbl_cnt),
    .rd_hit    (up_hit),
    .rd_taken  (up_taken_pred),
    .rd_next   (up_next),
    .rd_target (up_old_tgt),
    .rd_cnt    (up_cnt)
  );

  // Write data for the indexed entry.
  always_comb begin
    wr_idx = upd_pc[OFF_W +: IDX_W];
    wr_tag = upd_pc[ADDR_W-1 -: TAG_W];
    if (up_hit) begin
      wr_cnt    = cnt_step(up_cnt, upd_taken);
      wr_target = upd_taken ? upd_target : up_old_tgt;
    end else begin
      wr_cnt    = cnt_alloc(upd_taken);
      wr_target = upd_target;
    end
  end

  // Resolution outcome against what the table would have predicted.
  always_comb begin
    upd_fix_addr = upd_taken ? upd_target : (upd_pc + ADDR_W'(4));
    upd_redirect = upd_en && (up_next != upd_fix_addr);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic ent_we;
    cnt_e ent_cnt_q;

    assign ent_we = upd_en && (wr_idx == IDX_W'(g));

    bhp_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ent (
      .clk        (clk),
      .rst_ok     (rst_ok),
      .wr_en      (ent_we),
      .wr_tag     (wr_tag),
      .wr_target  (wr_target),
      .wr_cnt     (wr_cnt),
      .ent_vld    (tbl_vld[g]),
      .ent_tag    (tbl_tag[g]),
      .ent_target (tbl_tgt[g]),
      .ent_cnt    (ent_cnt_q)
    );

    assign tbl_cnt[g] = ent_cnt_q;
  end

endmodule

// File: rtl/bhp_chk.sv
module bhp_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [ADDR_W-1:0] lk_pc,
  input logic [ADDR_W-1:0] pred_next,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic              upd_en,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_redirect
);

  // R3
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !pred_hit |-> (pred_next == lk_pc + ADDR_W'(4)));

  // R4
  nt_seq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (pred_hit && !pred_taken) |-> (pred_next == lk_pc + ADDR_W'(4)));

  // R4
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    pred_taken |-> pred_hit);

  // R5
  alloc_hit_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_en |=> ((lk_pc != $past(upd_pc)) || pred_hit));

  // R8
  redirect_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !upd_en |-> !upd_redirect);

endmodule

bind bht_predictor bhp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .lk_pc        (lk_pc),
  .pred_next    (pred_next),
  .pred_hit     (pred_hit),
  .pred_taken   (pred_taken),
  .upd_en       (upd_en),
  .upd_pc       (upd_pc),
  .upd_redirect (upd_redirect)
);

// File: tb/bht_predictor_bench.sv
module bht_predictor_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic [31:0] pred_next;
  logic        pred_hit;
  logic        pred_taken;
  logic        upd_en;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [31:0] upd_target;
  logic        upd_redirect;
  logic [31:0] upd_fix_addr;

  int checks;
  int errors;
  bit done;

  // Behavioural model of the table.
  bit          m_vld [16];
  int unsigned m_tag [16];
  logic [31:0] m_tgt [16];
  int          m_cnt [16];

  bht_predictor u_bht_predictor (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc        (lk_pc),
    .pred_next    (pred_next),
    .pred_hit     (pred_hit),
    .pred_taken   (pred_taken),
    .upd_en       (upd_en),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target),
    .upd_redirect (upd_redirect),
    .upd_fix_addr (upd_fix_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned m_idx(input logic [31:0] pc);
    return (pc >> 2) & 32'hf;
  endfunction

  function automatic int unsigned m_tg(input logic [31:0] pc);
    return pc >> 6;
  endfunction

  task automatic m_predict(input logic [31:0] pc, output bit hit,
                           output bit tk, output logic [31:0] nxt);
    int unsigned i;
    i   = m_idx(pc);
    hit = m_vld[i] && (m_tag[i] == m_tg(pc));
    tk  = hit && (m_cnt[i] >= 2);
    nxt = tk ? m_tgt[i] : pc + 32'd4;
  endtask

  task automatic m_update(input logic [31:0] pc, input bit tk, input logic [31:0] tg);
    int unsigned i;
    i = m_idx(pc);
    if (m_vld[i] && m_tag[i] == m_tg(pc)) begin
      if (tk) begin
        if (m_cnt[i] < 3) m_cnt[i]++;
        m_tgt[i] = tg;
      end else if (m_cnt[i] > 0) begin
        m_cnt[i]--;
      end
    end else begin
      m_vld[i] = 1'b1;
      m_tag[i] = m_tg(pc);
      m_tgt[i] = tg;
      m_cnt[i] = tk ? 2 : 1;
    end
  endtask

  // One cycle: drive, compare against the model, then advance the model.
  task automatic cyc(input string req, input logic [31:0] lpc, input bit ue,
                     input logic [31:0] upc, input bit ut, input logic [31:0] utg);
    bit eh, et, uh, utp;
    logic [31:0] en, un, fix;
    @(negedge clk);
    lk_pc = lpc; upd_en = ue; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    m_predict(lpc, eh, et, en);
    m_predict(upc, uh, utp, un);
    fix = ut ? utg : upc + 32'd4;
    check(req, "pred_hit",   {31'd0, pred_hit},   {31'd0, eh});
    check(req, "pred_taken", {31'd0, pred_taken}, {31'd0, et});
    check(req, "pred_next",  pred_next, en);
    check("R8", "upd_fix_addr", upd_fix_addr, fix);
    check("R8", "upd_redirect", {31'd0, upd_redirect}, {31'd0, (ue && un != fix)});
    @(posedge clk);
    if (ue) m_update(upc, ut, utg);
  endtask

  task automatic look(input string req, input logic [31:0] lpc);
    cyc(req, lpc, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic upd(input string req, input logic [31:0] upc, input bit ut,
                     input logic [31:0] utg);
    cyc(req, 32'h0, 1'b1, upc, ut, utg);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    checks = 0; errors = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = 0; m_tgt[i] = '0; m_cnt[i] = 0;
    end
    rst_n = 1'b0; lk_pc = 32'h100; upd_en = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_target = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1", "pred_hit in reset", {31'd0, pred_hit}, 32'd0);
    check("R1", "pred_next in reset", pred_next, 32'h104);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    look("R1", 32'h0000_2000);
    look("R1", 32'h0000_203c);

    // R5/R4: taken allocation gives weak taken
    a = 32'h0000_1010;
    upd("R5", a, 1'b1, 32'h0000_8000);
    look("R5", a);
    check("R5", "alloc taken next", pred_next, 32'h0000_8000);
    // R6: taken hit raises to strong and refreshes target
    upd("R6", a, 1'b1, 32'h0000_8800);
    look("R6", a);
    check("R6", "refreshed target", pred_next, 32'h0000_8800);
    // R7: first not-taken keeps taken, second flips
    upd("R7", a, 1'b0, 32'h0);
    look("R7", a);
    check("R7", "one wrong keeps taken", {31'd0, pred_taken}, 32'd1);
    upd("R7", a, 1'b0, 32'h0);
    look("R7", a);
    check("R7", "two wrong flips", {31'd0, pred_taken}, 32'd0);
    upd("R7", a, 1'b0, 32'h0);
    upd("R7", a, 1'b1, 32'h0000_8800);
    look("R7", a);
    check("R7", "one taken from strong nt", {31'd0, pred_taken}, 32'd0);
    upd("R7", a, 1'b1, 32'h0000_8800);
    look("R7", a);
    check("R7", "two taken flips", {31'd0, pred_taken}, 32'd1);

    // R5: not-taken allocation gives weak not taken
    b = 32'h0000_3024;
    upd("R5", b, 1'b0, 32'h0000_9999);
    look("R5", b);
    check("R5", "alloc nt hit", {31'd0, pred_hit}, 32'd1);
    check("R5", "alloc nt next", pred_next, b + 32'd4);

    // R10: no enable, no change
    cyc("R10", b, 1'b0, b, 1'b1, 32'h0000_7777);
    cyc("R10", b, 1'b0, b, 1'b1, 32'h0000_7777);
    look("R10", b);
    check("R10", "untouched", pred_next, b + 32'd4);

    // R9: same-cycle lookup and update of one entry
    cyc("R9", b, 1'b1, b, 1'b1, 32'h0000_7000);
    check("R9", "old contents seen", pred_next, b + 32'd4);
    look("R9", b);
    check("R9", "new contents next", pred_next, 32'h0000_7000);
    cyc("R9", 32'h0000_4038, 1'b1, 32'h0000_4038, 1'b1, 32'h0000_5000);
    check("R9", "unallocated same cycle", {31'd0, pred_hit}, 32'd0);

    // R2/R11: alias on the index with a different tag
    look("R2", a + 32'h40);
    check("R2", "alias misses", {31'd0, pred_hit}, 32'd0);
    upd("R11", a + 32'h40, 1'b1, 32'h0000_6000);
    look("R11", a);
    check("R11", "old pc evicted", {31'd0, pred_hit}, 32'd0);
    look("R11", a + 32'h40);
    check("R11", "new pc hits", pred_next, 32'h0000_6000);

    // R8/R3/R4: random traffic over aliasing PCs
    for (int n = 0; n < 600; n++) begin
      logic [31:0] lp, up, tg;
      lp = 32'h0000_1000 + 32'($urandom_range(0, 47)) * 32'd4;
      up = ($urandom_range(0, 3) == 0) ? lp
         : 32'h0000_1000 + 32'($urandom_range(0, 47)) * 32'd4;
      tg = 32'h0001_0000 + 32'($urandom_range(0, 3)) * 32'h100;
      cyc("R4", lp, 1'($urandom_range(0, 1)), up, 1'($urandom_range(0, 1)), tg);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule